// File: doc/BRIEF.md
# ASCII-hex to serial word transmitter

This block takes a string of ASCII hexadecimal characters from a host, turns every character into a four-bit nibble as it is written, and stores the nibbles in a small character buffer. With the default 32 characters, the buffer holds a 128-bit word. After a start strobe, the block drives a four-wire link to a remote receiver that holds a shift-indexed register. The four wires are a reset line, an enable line, a transmit clock and a data line.

A transfer has a fixed shape. First comes one reset pulse, with the clock and enable held low. Then enable is raised. For each bit, the block presents the data while the clock is low, raises the clock so that the receiver samples the bit, and lowers the clock again. Every one of these phases lasts a programmable number of system clocks. The host watches `busy` and `done` to know when the link has finished.

Top module: `hexlink_tx`

## Requirements
- R1: Characters '0' to '9' (bytes 0x30 to 0x39) decode to nibble values 0 to 9.
- R2: Uppercase characters 'A' to 'F' (bytes 0x41 to 0x46) decode to nibble values 10 to 15.
- R3: Every other byte decodes to nibble 0, and no error is raised. This includes lowercase letters.
- R4: Link bit number 4i+b carries bit b of the nibble from character i. Characters go out in load order, and within each nibble bit 0 goes out first.
- R5: An accepted start produces one reset pulse of exactly PHASE_CYC cycles before enable rises. Clock and enable stay low while reset is high.
- R6: Enable stays high from the first setup phase to the end of the last clock-low phase. The clock is high only while enable is high. Data does not change while the clock is high. Each clock-high phase lasts exactly PHASE_CYC cycles.
- R7: A transfer contains exactly NUM_CHARS*4 rising edges of the link clock.
- R8: `busy` is high for exactly PHASE_CYC*(1+3*NUM_CHARS*4) cycles. `done` is high for one cycle, the first cycle after `busy` falls. When idle, all four link lines are low.
- R9: A start strobe that arrives while `busy` is high is ignored. There is no second reset pulse, and the transfer is not restarted.
- R10: `in_ready` is high only when the block is idle and fewer than NUM_CHARS characters are stored. A byte is stored when `in_valid` and `in_ready` are both high. An accepted start rewinds the store position to character 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte is valid |
| in_char | input | 8 | ASCII character from the host |
| in_ready | output | 1 | Block can take a character |
| start | input | 1 | Starts a transfer when the block is idle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after a transfer ends |
| link_rst | output | 1 | Link reset line |
| link_en | output | 1 | Link enable line |
| link_clk | output | 1 | Link transmit clock |
| link_dat | output | 1 | Link data line |

## Verification
The assertions assume three things about the host. It loads a full set of characters before it strikes start. It offers bytes only while `in_ready` is high. It holds reset high from time zero. The bench keeps within these assumptions: it loads all NUM_CHARS characters on consecutive cycles, waits for `done` before the next load, and drives stray start strobes and bytes only in the middle of a transfer. Because of this, the ignore rules are exercised at the ports and the buffer contents are never left partly defined.

// File: rtl/hexlink_pkg.sv
package hexlink_pkg;

  localparam int CHAR_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } link_st_t;

  // ASCII hex digit to nibble; anything outside 0-9 / A-F yields zero
  function automatic logic [NIB_W-1:0] hex_nibble(input logic [CHAR_W-1:0] ch);
    logic [CHAR_W-1:0] t;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      t = ch - 8'h30;
      return t[NIB_W-1:0];
    end else if (ch >= 8'h41 && ch <= 8'h46) begin
      t = ch - 8'h37;
      return t[NIB_W-1:0];
    end
    return '0;
  endfunction

endpackage

// File: rtl/hexlink_charbuf.sv
module hexlink_charbuf
  import hexlink_pkg::*;
#(
  parameter int NUM_CHARS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [CHAR_W-1:0]            wr_char,
  input  logic                         clr_ptr,
  output logic                         full,
  input  logic [$clog2(NUM_CHARS)-1:0] rd_addr,
  output logic [NIB_W-1:0]             rd_nib
);
  localparam int ADDR_W = $clog2(NUM_CHARS);
  localparam int PTR_W  = $clog2(NUM_CHARS + 1);

  logic [NIB_W-1:0] mem [NUM_CHARS];
  logic [PTR_W-1:0] wr_ptr;

  // no reset on the storage so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[ADDR_W-1:0]] <= hex_nibble(wr_char);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_ptr) wr_ptr <= '0;
    else if (wr_en)     wr_ptr <= wr_ptr + 1'b1;
  end

  assign full   = (wr_ptr == PTR_W'(NUM_CHARS));
  assign rd_nib = mem[rd_addr];

endmodule

// File: rtl/hexlink_phase_timer.sv
module hexlink_phase_timer #(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic last
);
  localparam int CNT_W = $clog2(PHASE_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (last)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CNT_W'(PHASE_CYC - 1));

endmodule

// File: rtl/hexlink_ctrl.sv
module hexlink_ctrl
  import hexlink_pkg::*;
#(
  parameter int NUM_CHARS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         last,
  input  logic [NIB_W-1:0]             rd_nib,
  output logic [$clog2(NUM_CHARS)-1:0] rd_addr,
  output logic                         clr_ptr,
  output logic                         tmr_restart,
  output logic                         busy,
  output logic                         done,
  output logic                         link_rst,
  output logic                         link_en,
  output logic                         link_clk,
  output logic                         link_dat
);
  localparam int NBITS  = NUM_CHARS * NIB_W;
  localparam int BIT_W  = $clog2(NBITS);
  localparam int ADDR_W = $clog2(NUM_CHARS);

  link_st_t         st, nxt;
  logic [BIT_W-1:0] bit_idx, nxt_bit;
  logic             fin;
  logic             last_bit;
  logic [1:0]       sel;

  assign last_bit    = (bit_idx == BIT_W'(NBITS - 1));
  assign clr_ptr     = (st == ST_IDLE) && start;
  assign tmr_restart = (st == ST_IDLE);
  assign rd_addr     = nxt_bit[BIT_W-1 -: ADDR_W];
  assign sel         = nxt_bit[1:0];

  always_comb begin
    nxt     = st;
    nxt_bit = bit_idx;
    fin     = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt     = ST_RST;
        nxt_bit = '0;
      end
      ST_RST:   if (last) nxt = ST_SETUP;
      ST_SETUP: if (last) nxt = ST_HIGH;
      ST_HIGH:  if (last) nxt = ST_LOW;
      ST_LOW: if (last) begin
        if (last_bit) begin
          nxt = ST_IDLE;
          fin = 1'b1;
        end else begin
          nxt     = ST_SETUP;
          nxt_bit = bit_idx + 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_idx  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      link_rst <= 1'b0;
      link_en  <= 1'b0;
      link_clk <= 1'b0;
      link_dat <= 1'b0;
    end else begin
      st       <= nxt;
      bit_idx  <= nxt_bit;
      busy     <= (nxt != ST_IDLE);
      done     <= fin;
      link_rst <= (nxt == ST_RST);
      link_en  <= (nxt == ST_SETUP) || (nxt == ST_HIGH) || (nxt == ST_LOW);
      link_clk <= (nxt == ST_HIGH);
      if (nxt == ST_SETUP)                      link_dat <= rd_nib[sel];
      else if (nxt == ST_HIGH || nxt == ST_LOW) link_dat <= link_dat;
      else                                      link_dat <= 1'b0;
    end
  end

endmodule

// File: rtl/hexlink_tx.sv
module hexlink_tx
  import hexlink_pkg::*;
#(
  parameter int NUM_CHARS = 32,
  parameter int PHASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              in_ready,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              link_rst,
  output logic              link_en,
  output logic              link_clk,
  output logic              link_dat
);
  localparam int ADDR_W = $clog2(NUM_CHARS);

  logic              full;
  logic              clr_ptr;
  logic              tmr_restart;
  logic              last;
  logic [ADDR_W-1:0] rd_addr;
  logic [NIB_W-1:0]  rd_nib;

  assign in_ready = !busy && !full;

  hexlink_charbuf #(.NUM_CHARS(NUM_CHARS)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (in_valid && in_ready),
    .wr_char (in_char),
    .clr_ptr (clr_ptr),
    .full    (full),
    .rd_addr (rd_addr),
    .rd_nib  (rd_nib)
  );

  hexlink_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .last    (last)
  );

  hexlink_ctrl #(.NUM_CHARS(NUM_CHARS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .last        (last),
    .rd_nib      (rd_nib),
    .rd_addr     (rd_addr),
    .clr_ptr     (clr_ptr),
    .tmr_restart (tmr_restart),
    .busy        (busy),
    .done        (done),
    .link_rst    (link_rst),
    .link_en     (link_en),
    .link_clk    (link_clk),
    .link_dat    (link_dat)
  );

endmodule

// File: rtl/hexlink_tx_chk.sv
module hexlink_tx_chk #(
  parameter int PHASE_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic link_rst,
  input logic link_en,
  input logic link_clk,
  input logic link_dat
);
  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)           hi_len <= '0;
    else if (link_clk) hi_len <= hi_len + 1'b1;
    else               hi_len <= '0;
  end

  AST_RST_QUIET:  assert property (@(posedge clk) disable iff (rst) link_rst |-> (!link_clk && !link_en)); // R5
  AST_CLK_IN_EN:  assert property (@(posedge clk) disable iff (rst) link_clk |-> link_en); // R6
  AST_DAT_HOLD:   assert property (@(posedge clk) disable iff (rst) link_clk |-> $stable(link_dat)); // R6
  AST_HIGH_LEN:   assert property (@(posedge clk) disable iff (rst) $fell(link_clk) |-> (hi_len == 16'(PHASE_CYC))); // R6
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R8
  AST_DONE_ONCE:  assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !(link_rst || link_en || link_clk || link_dat)); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) in_ready |-> !busy); // R10

endmodule

bind hexlink_tx hexlink_tx_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .link_rst (link_rst),
  .link_en  (link_en),
  .link_clk (link_clk),
  .link_dat (link_dat)
);

// File: tb/tb_hexlink_tx.sv
module tb_hexlink_tx;
  localparam int NC = 32;
  localparam int P  = 2;
  localparam int NB = NC * 4;

  logic       clk = 1'b0, rst = 1'b1, in_valid = 1'b0, start = 1'b0;
  logic [7:0] in_char = 8'h0;
  logic       in_ready, busy, done, link_rst, link_en, link_clk, link_dat;

  always #10 clk = ~clk;

  hexlink_tx #(.NUM_CHARS(NC), .PHASE_CYC(P)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
    .start(start), .busy(busy), .done(done), .link_rst(link_rst), .link_en(link_en),
    .link_clk(link_clk), .link_dat(link_dat)
  );

  int checks = 0, errors = 0, cyc = 0;
  byte unsigned chars [NC];

  // receiver model and link monitor
  logic [NB-1:0] rx;
  int  rx_cnt, rst_cyc, rise_cnt, done_cnt, busy_cyc, hi_run;
  int  ctl_viol, order_viol, en_gap, stab_viol, len_viol, post_viol, ready_viol;
  bit  en_on, prev_clk, prev_dat;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_nib(input int c);
    if (c >= 48 && c <= 57) return 4'(c - 48);
    if (c >= 65 && c <= 70) return 4'(c - 55);
    return 4'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (!rst) begin
      if (busy) busy_cyc++;
      if (busy && in_ready) ready_viol++;
      if (done) begin
        done_cnt++;
        if (busy || link_en || link_clk || link_dat || link_rst) post_viol++;
      end
      if (link_rst) begin
        rst_cyc++; rx_cnt = 0; rx = '0;
        if (link_clk || link_en) ctl_viol++;
      end
      if (link_clk && !link_en) ctl_viol++;
      if (link_en && !en_on) begin
        en_on = 1'b1;
        if (rst_cyc == 0) order_viol++;
      end
      if (en_on && busy && !link_en) en_gap++;
      if (link_clk && !prev_clk) begin
        rise_cnt++;
        if (rx_cnt < NB) rx[rx_cnt] = link_dat;
        rx_cnt++;
      end
      if (link_clk && prev_clk && (link_dat != prev_dat)) stab_viol++;
      if (link_clk) hi_run++;
      else begin
        if (prev_clk && hi_run != P) len_viol++;
        hi_run = 0;
      end
      prev_clk = link_clk;
      prev_dat = link_dat;
    end
  end

  task automatic clear_mon();
    rx = '0; rx_cnt = 0; rst_cyc = 0; rise_cnt = 0; done_cnt = 0; busy_cyc = 0; hi_run = 0;
    ctl_viol = 0; order_viol = 0; en_gap = 0; stab_viol = 0; len_viol = 0; post_viol = 0;
    ready_viol = 0; en_on = 1'b0;
  endtask

  task automatic load_all();
    for (int k = 0; k < NC; k++) begin
      in_valid = 1'b1;
      in_char  = chars[k];
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R10 ready low when buffer full", 128'(in_ready), 128'(0));
  endtask

  task automatic run(input bit disturb);
    logic [NB-1:0] exp;
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000 && done_cnt == 0; i++) begin
      start    = disturb && (i == 50 || i == 300);
      in_valid = disturb && (i >= 10 && i < 100);
      in_char  = 8'h46;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8 one done pulse", 128'(done_cnt), 128'(1));
    chk(busy_cyc == P * (1 + 3 * NB), "R8 busy length", 128'(busy_cyc), 128'(P * (1 + 3 * NB)));
    chk(post_viol == 0, "R8 idle lines at done", 128'(post_viol), 128'(0));
    chk(rst_cyc == P, disturb ? "R9 no second reset" : "R5 reset width", 128'(rst_cyc), 128'(P));
    chk(ctl_viol == 0 && order_viol == 0, "R5 reset framing", 128'(ctl_viol + order_viol), 128'(0));
    chk(en_gap == 0, "R6 enable held", 128'(en_gap), 128'(0));
    chk(stab_viol == 0, "R6 data stable while clock high", 128'(stab_viol), 128'(0));
    chk(len_viol == 0, "R6 clock high width", 128'(len_viol), 128'(0));
    chk(rise_cnt == NB, disturb ? "R9 edge count undisturbed" : "R7 edge count", 128'(rise_cnt), 128'(NB));
    chk(ready_viol == 0, "R10 ready low while busy", 128'(ready_viol), 128'(0));
    for (int k = 0; k < NC; k++) begin
      logic [3:0] e;
      e = ref_nib(int'(chars[k]));
      exp[4*k +: 4] = e;
      if (chars[k] >= 8'h30 && chars[k] <= 8'h39)
        chk(rx[4*k +: 4] == e, "R1 digit decode", 128'(rx[4*k +: 4]), 128'(e));
      else if (chars[k] >= 8'h41 && chars[k] <= 8'h46)
        chk(rx[4*k +: 4] == e, "R2 letter decode", 128'(rx[4*k +: 4]), 128'(e));
      else
        chk(rx[4*k +: 4] == e, "R3 invalid decodes to zero", 128'(rx[4*k +: 4]), 128'(e));
    end
    chk(rx == exp, "R4 bit order", 128'(rx), 128'(exp));
  endtask

  initial begin
    clear_mon();
    prev_clk = 1'b0; prev_dat = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R8 reset state", 128'({busy, done}), 128'(0));
    chk({link_rst, link_en, link_clk, link_dat} == 4'b0, "R8 reset link lines",
        128'({link_rst, link_en, link_clk, link_dat}), 128'(0));
    chk(in_ready == 1'b1, "R10 ready after reset", 128'(in_ready), 128'(1));
    // every byte value once across eight transfers
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < NC; k++) chars[k] = 8'(t * NC + k);
      load_all();
      run(1'b0);
    end
    // all ones
    for (int k = 0; k < NC; k++) chars[k] = 8'h46;
    load_all();
    run(1'b0);
    // mixed digits with stray strobes and bytes mid-transfer
    for (int k = 0; k < NC; k++) chars[k] = (k % 16 < 10) ? 8'(48 + k % 16) : 8'(55 + k % 16);
    load_all();
    run(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule